// File: doc/BRIEF.md
# Word Serializer with Internal Wrap

The block turns a stream of parallel words into a single serial bit stream. A word-load strobe, sampled on the bit clock, stands for the word-clock event. It captures a 20-bit word, and the block shifts that word out one bit per bit clock, lowest bit first. A bit counter hands the next captured word to the shift register right after the last bit of the current one, so consecutive words follow each other with no idle bit.

Two serial outputs leave the block. The loopback output always carries the serial stream and feeds a receiver inside the chip. The line output carries the same stream in normal operation. While the wrap input is high, the line output is parked at a constant 1 and only the loopback path carries data. The serial stream does not depend on wrap, so entering or leaving wrap mode drops no bits and repeats none.

Top module: `wrap_serializer`

## Requirements
- R1: After a synchronous active-high reset, and until the first strobe, the line and loopback outputs are both 0 (wrap low).
- R2: The first strobe after reset loads the word into the shift register at that clock edge. Bit 0 of the word appears on the outputs right after that edge, and bit k appears k edges later.
- R3: A strobe at any point within a word stores the word in a holding register. The stored word is sent next. A strobe in the cycle that shows bit 19 feeds the word straight into the next word.
- R4: With wrap low, the line output equals the loopback output on every cycle.
- R5: With wrap high, the line output is 1, whatever the data.
- R6: The loopback output follows the serial stream unchanged while wrap toggles, with no slipped or repeated bit.
- R7: Exactly 20 bits are sent per word, with no gap. If no new strobe arrives within a word, the last captured word is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 20 | Parallel transmit word |
| load | input | 1 | Word-load strobe, one clock wide |
| wrap | input | 1 | 1 routes data to loopback only and parks the line high |
| line_o | output | 1 | External serial line bit |
| loop_o | output | 1 | Internal loopback serial bit |

## Verification
The assertions assume that the strobe and data are synchronous to the bit clock and steady around each edge, and that reset stays high for at least one clock. The bench drives every input one time unit after the rising edge, so these assumptions hold. It sweeps the strobe across every bit position of a word, skips strobes on some words so that a word repeats, and toggles wrap both for whole words and in the middle of a word. Every expected bit comes from a word model kept in the bench.

// File: rtl/wrap_serializer.sv
module wrap_serializer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         load,
  input  logic         wrap,
  output logic         line_o,
  output logic         loop_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  shreg, hold, next_word;
  logic [CW-1:0] cnt;
  logic          started;

  assign next_word = load ? din : hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      hold    <= '0;
      cnt     <= '0;
      started <= 1'b0;
    end else begin
      if (load) hold <= din;
      if (!started) begin
        if (load) begin
          shreg   <= din;
          cnt     <= '0;
          started <= 1'b1;
        end
      end else if (cnt == LAST) begin
        shreg <= next_word;
        cnt   <= '0;
      end else begin
        shreg <= {1'b0, shreg[W-1:1]};
        cnt   <= cnt + 1'b1;
      end
    end
  end

  assign loop_o = shreg[0];
  assign line_o = wrap | shreg[0];

  a_r1_reset_low: assert property (@(posedge clk) rst |=> !loop_o);
  a_r2_first_bit: assert property (@(posedge clk) disable iff (rst)
    (!started && load) |=> (loop_o == $past(din[0])));
  a_r3_next_word: assert property (@(posedge clk) disable iff (rst)
    (started && cnt == LAST) |=> (loop_o == $past(next_word[0])));
  a_r4_normal_match: assert property (@(posedge clk) disable iff (rst)
    !wrap |-> (line_o == loop_o));
  a_r5_wrap_high: assert property (@(posedge clk) disable iff (rst)
    wrap |-> line_o);
  a_r6_shift: assert property (@(posedge clk) disable iff (rst)
    (started && cnt != LAST) |=> (loop_o == $past(shreg[1])));
  a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: tb/wrap_serializer_test.sv
module wrap_serializer_test;
  localparam int W = 20;
  localparam int NW = 48;

  logic         clk = 0;
  logic         rst = 1;
  logic [W-1:0] din = '0;
  logic         load = 0;
  logic         wrap = 0;
  logic         line_o, loop_o;

  int checks = 0;
  int fails = 0;

  wrap_serializer #(.W(W)) uut (
    .clk(clk), .rst(rst), .din(din), .load(load), .wrap(wrap),
    .line_o(line_o), .loop_o(loop_o)
  );

  always #2 clk = ~clk;

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [W-1:0] word_of(int w);
    if (w < W) return W'(1) << w;
    return W'((w * 32'h3C5A7) ^ (w << 9) ^ 32'hA5A5A);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [W-1:0] cur, held;
    logic wr;
    tick(); tick();
    rst = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R1 line idle", line_o, 1'b0);
      chk("R1 loop idle", loop_o, 1'b0);
    end
    load = 1; din = word_of(0);
    cur = word_of(0); held = cur; wr = 0;
    tick();
    for (int w = 0; w < NW; w++) begin
      for (int k = 0; k < W; k++) begin
        chk(w == 0 ? "R2 loop bit" : "R3 R6 R7 loop bit", loop_o, cur[k]);
        if (wr) chk("R5 line parked", line_o, 1'b1);
        else chk("R4 line bit", line_o, cur[k]);
        load = 0; din = ~word_of(w + 1);
        if (k == (w * 7) % W && (w % 6) != 5) begin
          load = 1; din = word_of(w + 1); held = word_of(w + 1);
        end
        wr = ((w >= 10 && w < 14) || (w == 20 && k >= 7 && k < 13) ||
              (w == 33 && (k % 3) == 0)) ? 1'b1 : 1'b0;
        wrap = wr;
        if (k == W - 1) cur = held;
        tick();
      end
    end
    load = 0; wrap = 0; rst = 1;
    tick();
    rst = 0;
    chk("R1 line after reset", line_o, 1'b0);
    chk("R1 loop after reset", loop_o, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule